// File: doc/BRIEF.md
# Single-Error-Correcting Memory with Background Scrubbing

This block is a small word-addressed memory in which every 64-bit data word is kept together with 8 check bits of an extended Hamming code. Each read is checked and classified as clean, repaired, or beyond repair. A single flipped bit is fixed in the returned word and the repaired word is written back in place, so a transient upset does not linger in the array.

Reads are split into two phases. In the first cycle after acceptance the raw stored word is placed on the response bus under a speculative strobe, so a consumer can start work at once. One cycle later a confirming strobe presents the final word, either unchanged or repaired, together with its status code. Full-word writes store the data at once and commit the check bits one cycle later, so back-to-back writes stream at one per cycle. Byte-masked writes go through a read, merge, re-encode and write sequence. A scrubber steps through the addresses, one per refresh tick, and rewrites any word that holds a single-bit error. Host traffic always wins over scrubbing. A debug port flips chosen stored bits so that the error paths can be exercised.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A full-word write (all mask bits set) stores the word, and a later read of that address returns it with status 2'b00 (clean).
- R2: The status on a confirmed read is one of three codes: 2'b00 clean, 2'b01 single error repaired, 2'b10 error not repairable. 2'b11 never appears.
- R3: In the cycle after a read is accepted, `rsp_spec` is 1 and `rsp_data` holds the raw stored word. In the following cycle `rsp_valid` is 1 and `rsp_data` holds the final word with its status.
- R4: A single flipped bit, in either the data or the check field, gives the original data with status 2'b01. The repaired word is written back, so the next read of that address is clean.
- R5: Two flipped bits give the raw stored data with status 2'b10. Nothing is written back, so a repeat read reports 2'b10 again.
- R6: A write whose mask is not all ones replaces byte i (bits 8i+7..8i) where `req_bmask[i]` is 1 and keeps the other bytes of the stored word, repaired if they held a single-bit error. The merged word then reads back clean.
- R7: A full-word write is accepted in a single cycle. `req_ready` stays 1 in the next cycle, so consecutive full writes are taken every cycle and each reads back correctly.
- R8: Each `scrub_tick` causes one scrub of the next address in ascending order. The order starts at 0 after reset and wraps after the last address. A single-bit error found by a scrub is repaired in the array.
- R9: A pending scrub waits while `req_valid` is high. While a scrub is in progress, `req_ready` is 0.
- R10: When `dbg_flip_en` is 1, the stored word at `dbg_flip_addr` is XORed with `dbg_flip_bits`. Bits [63:0] act on the data and bits [71:64] act on the check bits.
- R11: After reset, `req_ready` is 1 and `rsp_spec` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | DW (64) | Write data |
| req_bmask | input | DW/8 (8) | Byte enables for a write |
| rsp_spec | output | 1 | Raw, unchecked read data on `rsp_data` |
| rsp_valid | output | 1 | Checked read data and status on the outputs |
| rsp_data | output | DW (64) | Read data |
| rsp_status | output | 2 | Read outcome code |
| scrub_tick | input | 1 | Refresh tick that requests one scrub step |
| dbg_flip_en | input | 1 | Apply the bit-flip mask |
| dbg_flip_addr | input | ADDR_W (4) | Address of the word to corrupt |
| dbg_flip_bits | input | DW+8 (72) | XOR mask: [63:0] data, [71:64] check bits |

## Verification
A wrong syndrome or merge shows up at once, as wrong data or status in the confirming cycle of the read that meets it. A write-back that is missing or stored with bad check bits does not show on that read. It appears only on the next read of the same address, as a repeated 2'b01 or a wrong code. For that reason every injected error is read twice. A scrub pointer that is out of step is invisible until a later read finds a word still marked repaired or one already cleaned. So the bench corrupts two neighbouring addresses and walks the pointer through a full wrap.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

    typedef enum logic [1:0] {
        ST_OK  = 2'b00,
        ST_FIX = 2'b01,
        ST_BAD = 2'b10
    } ecc_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CHK,
        S_RD_DONE,
        S_RMW_RD,
        S_RMW_WR,
        S_SCR_RD,
        S_SCR_WB
    } fsm_e;

    // number of Hamming bits r with 2^r >= data + r + 1
    function automatic int ham_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // codeword position (1-based) of data bit j: the j-th non power of two from 3 on
    function automatic int data_pos(input int j);
        int n;
        n = -1;
        for (int q = 3; q < 512; q++) begin
            if ((q & (q - 1)) != 0) begin
                n++;
                if (n == j) return q;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import ecc_scrub_pkg::*;
#(
    parameter int DW = 64,
    parameter int HW = 7
) (
    input  logic [DW-1:0] data,
    output logic [HW:0]   chk
);
    always_comb begin
        chk = '0;
        for (int j = 0; j < DW; j++) begin
            int p;
            p = data_pos(j);
            for (int i = 0; i < HW; i++) begin
                if (p[i]) chk[i] = chk[i] ^ data[j];
            end
        end
        // overall parity makes the XOR of all stored bits zero
        chk[HW] = (^data) ^ (^chk[HW-1:0]);
    end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import ecc_scrub_pkg::*;
#(
    parameter int DW = 64,
    parameter int HW = 7
) (
    input  logic [DW-1:0] data,
    input  logic [HW:0]   chk,
    output logic [DW-1:0] fixed,
    output ecc_status_e   status
);
    logic [HW-1:0] syn;
    logic          odd;
    logic          hit;

    always_comb begin
        syn = chk[HW-1:0];
        for (int j = 0; j < DW; j++) begin
            int p;
            p = data_pos(j);
            for (int i = 0; i < HW; i++) begin
                if (p[i]) syn[i] = syn[i] ^ data[j];
            end
        end
        odd   = (^data) ^ (^chk);
        fixed = data;
        hit   = 1'b0;
        for (int j = 0; j < DW; j++) begin
            if (data_pos(j) == int'(syn)) begin
                fixed[j] = ~data[j];
                hit      = 1'b1;
            end
        end
        if (syn == '0 && !odd) begin
            status = ST_OK;
        end else if (odd && (syn == '0 || (syn & (syn - 1'b1)) == '0 || hit)) begin
            status = ST_FIX;  // overall bit, a check bit, or a data bit
        end else begin
            status = ST_BAD;
            fixed  = data;
        end
    end
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
    import ecc_scrub_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int HW     = ham_bits(DW),
    localparam int CW     = HW + 1,
    localparam int NB     = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [NB-1:0]     req_bmask,
    output logic              rsp_spec,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_data,
    output logic [1:0]        rsp_status,
    input  logic              scrub_tick,
    input  logic              dbg_flip_en,
    input  logic [ADDR_W-1:0] dbg_flip_addr,
    input  logic [DW+CW-1:0]  dbg_flip_bits
);
    typedef struct packed {
        fsm_e              state;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [DW-1:0]     wdata;
        logic [NB-1:0]     mask;
        ecc_status_e       status;
        logic [ADDR_W-1:0] sptr;
        logic              spend;
        logic              ck_pend;
        logic [ADDR_W-1:0] ck_addr;
        logic [CW-1:0]     ck_bits;
    } regs_t;

    regs_t r_q, r_d;

    logic [DW-1:0] mem_d [DEPTH];
    logic [CW-1:0] mem_c [DEPTH];

    logic [DW-1:0]     raw_d;
    logic [CW-1:0]     raw_c;
    logic [DW-1:0]     dec_fixed;
    ecc_status_e       dec_status;
    logic [DW-1:0]     enc_in;
    logic [CW-1:0]     enc_chk;
    logic              dwe, cwe, acc_full;
    logic [ADDR_W-1:0] dwaddr, cwaddr;
    logic [DW-1:0]     dwdata;
    logic [CW-1:0]     cwdata;

    assign raw_d = mem_d[r_q.addr];
    assign raw_c = mem_c[r_q.addr];

    secded_decoder #(.DW(DW), .HW(HW)) u_dec (
        .data(raw_d), .chk(raw_c), .fixed(dec_fixed), .status(dec_status)
    );

    always_comb enc_in = (r_q.state == S_IDLE) ? req_wdata : r_q.data;

    secded_encoder #(.DW(DW), .HW(HW)) u_enc (.data(enc_in), .chk(enc_chk));

    always_comb begin
        r_d        = r_q;
        r_d.ck_pend = 1'b0;
        dwe        = 1'b0;
        cwe        = 1'b0;
        dwaddr     = r_q.addr;
        cwaddr     = r_q.addr;
        dwdata     = r_q.data;
        cwdata     = enc_chk;
        acc_full   = 1'b0;
        req_ready  = 1'b0;
        rsp_spec   = 1'b0;
        rsp_valid  = 1'b0;
        rsp_data   = '0;
        rsp_status = ST_OK;

        // deferred check-bit commit of the previous full write
        if (r_q.ck_pend) begin
            cwe    = 1'b1;
            cwaddr = r_q.ck_addr;
            cwdata = r_q.ck_bits;
        end
        if (scrub_tick) r_d.spend = 1'b1;

        case (r_q.state)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.mask  = req_bmask;
                    if (req_write && (&req_bmask)) begin
                        acc_full    = 1'b1;
                        dwe         = 1'b1;
                        dwaddr      = req_addr;
                        dwdata      = req_wdata;
                        r_d.ck_pend = 1'b1;
                        r_d.ck_addr = req_addr;
                        r_d.ck_bits = enc_chk;
                    end else if (req_write) begin
                        r_d.state = S_RMW_RD;
                    end else begin
                        r_d.state = S_RD_CHK;
                    end
                end else if (r_q.spend) begin
                    r_d.spend = scrub_tick;
                    r_d.addr  = r_q.sptr;
                    r_d.state = S_SCR_RD;
                end
            end
            S_RD_CHK: begin
                rsp_spec   = 1'b1;
                rsp_data   = raw_d;
                r_d.data   = dec_fixed;
                r_d.status = dec_status;
                r_d.state  = S_RD_DONE;
            end
            S_RD_DONE: begin
                rsp_valid  = 1'b1;
                rsp_data   = r_q.data;
                rsp_status = r_q.status;
                if (r_q.status == ST_FIX) begin
                    dwe    = 1'b1;
                    cwe    = 1'b1;
                    cwaddr = r_q.addr;
                    cwdata = enc_chk;
                end
                r_d.state = S_IDLE;
            end
            S_RMW_RD: begin
                for (int b = 0; b < NB; b++) begin
                    r_d.data[8*b +: 8] = r_q.mask[b] ? r_q.wdata[8*b +: 8]
                                                     : dec_fixed[8*b +: 8];
                end
                r_d.state = S_RMW_WR;
            end
            S_RMW_WR, S_SCR_WB: begin
                dwe       = 1'b1;
                cwe       = 1'b1;
                cwaddr    = r_q.addr;
                cwdata    = enc_chk;
                r_d.state = S_IDLE;
            end
            S_SCR_RD: begin
                r_d.data   = dec_fixed;
                r_d.status = dec_status;
                r_d.sptr   = (r_q.sptr == ADDR_W'(DEPTH - 1)) ? '0 : r_q.sptr + 1'b1;
                r_d.state  = (dec_status == ST_FIX) ? S_SCR_WB : S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= S_IDLE;
            r_q.status  <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] <= '0;
                mem_c[i] <= '0;
            end
        end else begin
            if (dwe) mem_d[dwaddr] <= dwdata;
            if (cwe) mem_c[cwaddr] <= cwdata;
            if (dbg_flip_en) begin
                mem_d[dbg_flip_addr] <= ((dwe && dwaddr == dbg_flip_addr) ? dwdata
                                         : mem_d[dbg_flip_addr]) ^ dbg_flip_bits[DW-1:0];
                mem_c[dbg_flip_addr] <= ((cwe && cwaddr == dbg_flip_addr) ? cwdata
                                         : mem_c[dbg_flip_addr]) ^ dbg_flip_bits[DW+CW-1:DW];
            end
        end
    end

    // R3: confirmation always follows a speculative cycle
    a_r3_valid_after_spec: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rsp_spec));

    // R2: only three status codes are reported
    a_r2_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11));

    // R4: a clean decode leaves the word untouched
    a_r4_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RD_CHK && dec_status == ST_OK) |-> (dec_fixed == raw_d));

    // R5: an unrepairable read writes nothing back
    a_r5_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RD_DONE && r_q.status == ST_BAD) |-> (!dwe && !cwe));

    // R7: data lands on the accept edge, check bits are committed next
    a_r7_split_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_full && !dbg_flip_en) |-> (r_q.ck_pend && mem_d[r_q.ck_addr] == r_q.wdata));

    // R8: every scrub read advances the pointer
    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_q.state == S_SCR_RD) |-> (r_q.sptr != $past(r_q.sptr)));

    // R9: a scrub starts only when the host was idle
    a_r9_host_first: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_SCR_RD) |-> $past(!req_valid));

endmodule

// File: tb/ecc_scrub_mem_test.sv
module ecc_scrub_mem_test;
    localparam int DW = 64;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [7:0]    req_bmask = '0;
    logic          rsp_spec, rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [1:0]    rsp_status;
    logic          scrub_tick = 1'b0;
    logic          dbg_flip_en = 1'b0;
    logic [AW-1:0] dbg_flip_addr = '0;
    logic [71:0]   dbg_flip_bits = '0;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    ecc_scrub_mem uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rsp_spec(rsp_spec), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_status(rsp_status), .scrub_tick(scrub_tick),
        .dbg_flip_en(dbg_flip_en), .dbg_flip_addr(dbg_flip_addr),
        .dbg_flip_bits(dbg_flip_bits)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return 64'h0123_4567_89AB_CDEF + 64'(a) * 64'h1111_1111_1111_1111;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] nw,
                                            input logic [7:0] m);
        logic [DW-1:0] res;
        for (int b = 0; b < 8; b++) res[8*b +: 8] = m[b] ? nw[8*b +: 8] : old[8*b +: 8];
        return res;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input logic [7:0] m);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_bmask = m;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        wait_ready();
    endtask

    task automatic do_read(input int a, output logic sp, output logic [DW-1:0] sd,
                           output logic v, output logic [DW-1:0] d, output logic [1:0] s);
        wait_ready();
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        sp = rsp_spec; sd = rsp_data;
        @(posedge clk); @(negedge clk);
        v = rsp_valid; d = rsp_data; s = rsp_status;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic flip(input int a, input logic [71:0] bits);
        dbg_flip_en = 1'b1; dbg_flip_addr = AW'(a); dbg_flip_bits = bits;
        @(posedge clk); @(negedge clk);
        dbg_flip_en = 1'b0; dbg_flip_bits = '0;
    endtask

    task automatic scrub_once();
        scrub_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        scrub_tick = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 ready after reset", 64'(req_ready), 64'd1);
        check("R11 spec after reset", 64'(rsp_spec), 64'd0);
        check("R11 valid after reset", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_clean();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        for (int a = 0; a < 16; a++) do_write(a, pat(a), 8'hFF);
        do_read(3, sp, sd, v, d, s);
        check("R3 spec strobe", 64'(sp), 64'd1);
        check("R3 spec data", sd, pat(3));
        check("R3 valid strobe", 64'(v), 64'd1);
        check("R1 read data", d, pat(3));
        check("R1 R2 clean status", 64'(s), 64'd0);
    endtask

    task automatic t_back2back();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        wait_ready();
        req_valid = 1'b1; req_write = 1'b1; req_bmask = 8'hFF;
        req_addr = 4'd4; req_wdata = 64'hDEAD_BEEF_0000_0004;
        @(posedge clk); @(negedge clk);
        check("R7 ready during burst", 64'(req_ready), 64'd1);
        req_addr = 4'd5; req_wdata = 64'hCAFE_F00D_0000_0005;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        do_read(4, sp, sd, v, d, s);
        check("R7 first burst word", d, 64'hDEAD_BEEF_0000_0004);
        check("R7 first burst status", 64'(s), 64'd0);
        do_read(5, sp, sd, v, d, s);
        check("R7 second burst word", d, 64'hCAFE_F00D_0000_0005);
        check("R7 second burst status", 64'(s), 64'd0);
    endtask

    task automatic t_single_data();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        flip(6, 72'(1) << 17);
        do_read(6, sp, sd, v, d, s);
        check("R3 R10 raw spec data", sd, pat(6) ^ (64'd1 << 17));
        check("R4 repaired data", d, pat(6));
        check("R4 repaired status", 64'(s), 64'd1);
        do_read(6, sp, sd, v, d, s);
        check("R4 write-back clean", 64'(s), 64'd0);
        check("R4 write-back data", sd, pat(6));
    endtask

    task automatic t_single_chk();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        flip(7, 72'(1) << 66);
        do_read(7, sp, sd, v, d, s);
        check("R4 R10 check-bit error data", d, pat(7));
        check("R4 check-bit error status", 64'(s), 64'd1);
        do_read(7, sp, sd, v, d, s);
        check("R4 check-bit write-back", 64'(s), 64'd0);
    endtask

    task automatic t_double();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        logic [DW-1:0] bad;
        bad = pat(8) ^ (64'd1 << 2) ^ (64'd1 << 40);
        flip(8, (72'(1) << 2) | (72'(1) << 40));
        do_read(8, sp, sd, v, d, s);
        check("R5 raw data returned", d, bad);
        check("R5 R2 unrepairable status", 64'(s), 64'd2);
        do_read(8, sp, sd, v, d, s);
        check("R5 no write-back data", d, bad);
        check("R5 no write-back status", 64'(s), 64'd2);
        do_write(8, pat(8), 8'hFF);
    endtask

    task automatic t_partial();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        do_write(9, 64'hFFFF_FFFF_FFFF_FFFF, 8'b0000_1000);
        do_read(9, sp, sd, v, d, s);
        check("R6 merged byte", d, merge(pat(9), 64'hFFFF_FFFF_FFFF_FFFF, 8'b0000_1000));
        check("R6 merged status", 64'(s), 64'd0);
        flip(10, 72'(1));
        do_write(10, 64'h5A00_0000_0000_0000, 8'h80);
        do_read(10, sp, sd, v, d, s);
        check("R6 merge over repaired word", d, merge(pat(10), 64'h5A00_0000_0000_0000, 8'h80));
        check("R6 merge over repaired status", 64'(s), 64'd0);
    endtask

    task automatic t_scrub();
        logic sp, v; logic [DW-1:0] sd, d; logic [1:0] s;
        flip(0, 72'(1) << 5);
        flip(1, 72'(1) << 9);
        scrub_once();
        do_read(0, sp, sd, v, d, s);
        check("R8 scrub starts at address 0", sd, pat(0));
        check("R8 scrubbed status", 64'(s), 64'd0);
        do_read(1, sp, sd, v, d, s);
        check("R8 next address untouched", 64'(s), 64'd1);
        for (int k = 0; k < 15; k++) scrub_once();
        flip(0, 72'(1) << 33);
        scrub_once();
        do_read(0, sp, sd, v, d, s);
        check("R8 pointer wraps to 0", 64'(s), 64'd0);
        check("R8 wrapped scrub data", d, pat(0));
    endtask

    task automatic t_priority();
        logic [DW-1:0] d; logic [1:0] s;
        // tick and host request together: the host goes first
        scrub_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        scrub_tick = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd3;
        check("R9 host accepted over pending scrub", 64'(req_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R9 host read served first", 64'(rsp_spec), 64'd1);
        repeat (6) @(negedge clk);
        // a scrub in progress stalls the host
        scrub_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        scrub_tick = 1'b0;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd3;
        check("R9 ready low during scrub", 64'(req_ready), 64'd0);
        wait_ready();
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        d = rsp_data; s = rsp_status;
        check("R9 stalled read data", d, pat(3));
        check("R9 stalled read status", 64'(s), 64'd0);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_back2back();
        t_single_data();
        t_single_chk();
        t_double();
        t_partial();
        t_scrub();
        t_priority();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule